// File: doc/BRIEF.md
# Sequential Multi-Level Trigger Unit

This unit watches a set of sampled probe bits and a compare bus, and produces a single trigger pulse once an ordered chain of conditions has been met, one after another. Up to ten conditions, called levels, can be chained. Only the level the pointer currently names is examined on each rising edge of the sample clock. When that level is true, the pointer moves on to the next level. When the last configured level is true, the trigger fires.

Each level is one of two kinds. A basic level tests one chosen probe bit for high, low, a rising edge or a falling edge. An advanced level requires a chosen probe bit to be 1 and the masked compare bus to equal a stored value, so it can express an equation such as "enable and bus equals 15". Configuration is given as flat per-level input vectors. The unit starts idle after reset and is started or restarted with a synchronous arm strobe.

Top module: `seq_trigger`

## Requirements
- R1: After reset the unit is idle: `trig` is 0 and `level` is 0. Until `arm` is asserted, no probe pattern produces a trigger.
- R2: On any clock edge where `arm` is 1, the level pointer returns to 0 and the unit starts evaluating. No condition is evaluated on that edge. This also applies while the unit is running or after it has fired.
- R3: Only the level named by the pointer is evaluated. Conditions of later levels that are true have no effect while an earlier level is pending.
- R4: The pointer advances by at most one level per clock edge, so consecutive levels that are all true take one edge each.
- R5: When the last configured level is true, `trig` is 1 for exactly one cycle. The unit then holds in a fired state, with `level` unchanged and no further pulses, until it is re-armed.
- R6: For a basic level (its `lvl_adv` bit is 0), the 2-bit field in `lvl_mode` selects the test on the probe bit chosen by its `lvl_sel` field: 00 tests for high, 01 for low, 10 for a rising edge and 11 for a falling edge. An edge is judged against the value of the probe bit on the previous clock edge.
- R7: For an advanced level (its `lvl_adv` bit is 1), the level is true when the probe bit chosen by its `lvl_sel` field is 1 and (`bus` & mask) equals its compare value.
- R8: A `num_lvls` of 0 behaves as 1. A value above the maximum level count behaves as the maximum.
- R9: While the current level is false, `level` holds its value and `trig` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; all evaluation happens on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm | input | 1 | Synchronous start/restart strobe |
| probe | input | NPROBE | Sampled probe bits |
| bus | input | BUSW | Compare bus used by advanced levels |
| lvl_adv | input | NLVL | Per level: 1 selects advanced, 0 selects basic |
| lvl_sel | input | NLVL*SELW | Per level: probe bit index; level i at bits [i*SELW +: SELW] |
| lvl_mode | input | 2*NLVL | Per level: basic match mode; level i at bits [2i +: 2] |
| lvl_mask | input | NLVL*BUSW | Per level: bus mask for advanced levels |
| lvl_val | input | NLVL*BUSW | Per level: compare value for advanced levels |
| num_lvls | input | CNTW | Number of levels in the chain |
| trig | output | 1 | One-cycle trigger pulse |
| level | output | LVLW | Index of the level currently awaited, starting at 0 |

## Verification
The in-line assertions check on every cycle that the trigger is a single-cycle pulse, that arming clears the pointer, that the pointer moves by at most one step, and that it holds while the current level is false, while idle and after firing. The decoding of the four basic modes, the advanced mask-and-compare equation, the blindness to later levels, and the clamping of the level count can only be shown by the directed scenarios, which drive known probe and bus patterns and compare `trig` and `level` with values derived from the requirements.

// File: rtl/seq_trigger.sv
module seq_trigger #(
  parameter int NPROBE = 8,
  parameter int BUSW   = 4,
  parameter int NLVL   = 10,
  localparam int SELW  = (NPROBE > 1) ? $clog2(NPROBE) : 1,
  localparam int LVLW  = (NLVL > 1) ? $clog2(NLVL) : 1,
  localparam int CNTW  = $clog2(NLVL + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 arm,
  input  logic [NPROBE-1:0]    probe,
  input  logic [BUSW-1:0]      bus,
  input  logic [NLVL-1:0]      lvl_adv,
  input  logic [NLVL*SELW-1:0] lvl_sel,
  input  logic [2*NLVL-1:0]    lvl_mode,
  input  logic [NLVL*BUSW-1:0] lvl_mask,
  input  logic [NLVL*BUSW-1:0] lvl_val,
  input  logic [CNTW-1:0]      num_lvls,
  output logic                 trig,
  output logic [LVLW-1:0]      level
);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DONE} st_t;

  st_t               st;
  logic [NPROBE-1:0] probe_q;
  logic [NLVL-1:0]   hit;
  logic [LVLW-1:0]   last;
  logic              cur_hit;

  for (genvar g = 0; g < NLVL; g++) begin : g_lvl
    logic [SELW-1:0] sel;
    logic [1:0]      mode;
    logic            now_b, prv_b, basic, adv;

    assign sel   = lvl_sel[g*SELW +: SELW];
    assign mode  = lvl_mode[2*g +: 2];
    assign now_b = probe[sel];
    assign prv_b = probe_q[sel];
    assign adv   = now_b && ((bus & lvl_mask[g*BUSW +: BUSW]) == lvl_val[g*BUSW +: BUSW]);

    always_comb begin
      case (mode)
        2'b00:   basic = now_b;
        2'b01:   basic = !now_b;
        2'b10:   basic = now_b && !prv_b;
        default: basic = !now_b && prv_b;
      endcase
    end

    assign hit[g] = lvl_adv[g] ? adv : basic;
  end

  always_comb begin
    if (num_lvls == '0)
      last = '0;
    else if (num_lvls > CNTW'(NLVL))
      last = LVLW'(NLVL - 1);
    else
      last = LVLW'(num_lvls - 1'b1);
  end

  assign cur_hit = hit[level];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      level   <= '0;
      trig    <= 1'b0;
      probe_q <= '0;
    end else begin
      probe_q <= probe;
      trig    <= 1'b0;
      if (arm) begin
        st    <= S_RUN;
        level <= '0;
      end else if (st == S_RUN && cur_hit) begin
        if (level >= last) begin
          st   <= S_DONE;
          trig <= 1'b1;
        end else begin
          level <= level + 1'b1;
        end
      end
    end
  end

  a_r5_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> !trig);

  a_r2_arm_restart: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> (level == '0 && !trig));

  a_r4_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!arm && st == S_RUN) |=> (level == $past(level) || level == LVLW'($past(level) + 1'b1)));

  a_r9_hold_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (!arm && st == S_RUN && !cur_hit) |=> ($stable(level) && !trig));

  a_r5_fired_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!arm && st == S_DONE) |=> (!trig && $stable(level)));

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!arm && st == S_IDLE) |=> (!trig && level == '0));

endmodule

// File: tb/seq_trigger_bench.sv
module seq_trigger_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NPROBE = 8;
  localparam int BUSW   = 4;
  localparam int NLVL   = 10;
  localparam int SELW   = 3;
  localparam int LVLW   = 4;
  localparam int CNTW   = 4;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 arm = 1'b0;
  logic [NPROBE-1:0]    probe = '0;
  logic [BUSW-1:0]      bus = '0;
  logic [NLVL-1:0]      lvl_adv = '0;
  logic [NLVL*SELW-1:0] lvl_sel = '0;
  logic [2*NLVL-1:0]    lvl_mode = '0;
  logic [NLVL*BUSW-1:0] lvl_mask = '0;
  logic [NLVL*BUSW-1:0] lvl_val = '0;
  logic [CNTW-1:0]      num_lvls = '0;
  logic                 trig;
  logic [LVLW-1:0]      level;

  int vecs = 0;
  int errs = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seq_trigger #(.NPROBE(NPROBE), .BUSW(BUSW), .NLVL(NLVL)) u_seq_trigger (
    .clk(clk), .rst_n(rst_n), .arm(arm), .probe(probe), .bus(bus),
    .lvl_adv(lvl_adv), .lvl_sel(lvl_sel), .lvl_mode(lvl_mode),
    .lvl_mask(lvl_mask), .lvl_val(lvl_val), .num_lvls(num_lvls),
    .trig(trig), .level(level));

  task automatic chk(string tag, int act, int exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_arm();
    arm = 1'b1;
    tick();
    arm = 1'b0;
  endtask

  task automatic set_lvl(int i, bit adv, int sel, int mode, int mask, int val);
    lvl_adv[i]              = adv;
    lvl_sel[i*SELW +: SELW] = SELW'(sel);
    lvl_mode[2*i +: 2]      = 2'(mode);
    lvl_mask[i*BUSW +: BUSW] = BUSW'(mask);
    lvl_val[i*BUSW +: BUSW]  = BUSW'(val);
  endtask

  task automatic t_reset_idle();
    chk("R1 trig after reset", int'(trig), 0);
    chk("R1 level after reset", int'(level), 0);
    set_lvl(0, 0, 0, 0, 0, 0);
    num_lvls = 1;
    probe = 8'h01;
    for (int k = 0; k < 4; k++) begin
      tick();
      chk("R1 no trigger while unarmed", int'(trig), 0);
    end
    probe = '0;
  endtask

  task automatic t_basic_modes();
    num_lvls = 1;
    for (int m = 0; m < 4; m++) begin
      set_lvl(0, 0, 2, m, 0, 0);
      probe = (m == 0 || m == 2) ? 8'h00 : 8'h04;
      do_arm();
      tick(); tick();
      chk("R6 idle value no match", int'(trig), 0);
      probe = (m == 0 || m == 2) ? 8'h04 : 8'h00;
      tick();
      chk("R6 mode match fires", int'(trig), 1);
      tick();
      chk("R5 pulse one cycle", int'(trig), 0);
      if (m >= 2) begin
        do_arm();
        tick();
        chk("R6 level held without edge", int'(trig), 0);
      end
    end
  endtask

  task automatic t_sequence();
    num_lvls = 3;
    set_lvl(0, 0, 0, 0, 0, 0);
    set_lvl(1, 0, 1, 0, 0, 0);
    set_lvl(2, 0, 2, 0, 0, 0);
    probe = '0;
    do_arm();
    probe = 8'h06;
    tick(); tick();
    chk("R3 later levels ignored", int'(level), 0);
    chk("R3 no trigger", int'(trig), 0);
    probe = 8'h07;
    tick(); chk("R4 step to 1", int'(level), 1); chk("R4 no trig", int'(trig), 0);
    tick(); chk("R4 step to 2", int'(level), 2); chk("R4 no trig", int'(trig), 0);
    tick(); chk("R5 fires at last", int'(trig), 1); chk("R5 level at last", int'(level), 2);
    for (int k = 0; k < 3; k++) begin
      tick();
      chk("R5 held after fire", int'(trig), 0);
      chk("R5 level held", int'(level), 2);
    end
    probe = 8'h01;
    do_arm();
    chk("R2 rearm clears pointer", int'(level), 0);
    tick(); chk("R9 advance to 1", int'(level), 1);
    probe = 8'h00;
    tick(); tick();
    chk("R9 pending holds", int'(level), 1);
    chk("R9 no trig", int'(trig), 0);
    do_arm();
    chk("R2 rearm mid run", int'(level), 0);
  endtask

  task automatic t_advanced();
    num_lvls = 1;
    set_lvl(0, 1, 5, 0, 4'hF, 4'hF);
    probe = 8'h00; bus = 4'hF;
    do_arm();
    tick(); chk("R7 enable low blocks", int'(trig), 0);
    probe = 8'h20; bus = 4'hE;
    tick(); chk("R7 bus mismatch blocks", int'(trig), 0);
    bus = 4'hF;
    tick(); chk("R7 enable and bus==15 fires", int'(trig), 1);
    set_lvl(0, 1, 5, 0, 4'h3, 4'h1);
    bus = 4'hC;
    do_arm();
    tick(); chk("R7 masked mismatch", int'(trig), 0);
    bus = 4'hD;
    tick(); chk("R7 masked match fires", int'(trig), 1);
    bus = '0;
  endtask

  task automatic t_count();
    set_lvl(0, 0, 0, 0, 0, 0);
    set_lvl(1, 0, 7, 0, 0, 0);
    num_lvls = 0;
    probe = 8'h01;
    do_arm();
    tick(); chk("R8 count 0 acts as 1", int'(trig), 1);
    for (int i = 0; i < NLVL; i++) set_lvl(i, 0, 0, 0, 0, 0);
    num_lvls = 15;
    do_arm();
    for (int k = 1; k < NLVL; k++) begin
      tick();
      chk("R8 clamped chain no early trig", int'(trig), 0);
      chk("R8 clamped chain level", int'(level), k);
    end
    tick();
    chk("R8 clamped to max fires", int'(trig), 1);
    chk("R8 level at max", int'(level), NLVL - 1);
    probe = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset_idle();
    t_basic_modes();
    t_sequence();
    t_advanced();
    t_count();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule